// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Antibacklash Hold

This block compares two divided clock signals, a reference and a feedback, and produces the pump-up and pump-down requests for a charge pump. Both inputs are treated as asynchronous. A fast sample clock brings them into its own domain, and the block models the detector on that clock. A rising edge on the reference input sets a reference flag, and a rising edge on the feedback input sets a feedback flag. Once both flags are up, they stay up together for a programmable number of sample cycles and then clear in the same cycle. Because of this hold, even a zero phase error gives a pulse of minimum width on both outputs, so the transfer function has no dead zone.

Two static controls act on the outputs. The polarity control exchanges the up and down requests, for oscillators whose frequency falls as the tuning voltage rises. The pump-enable control forces both requests low and reports the pump as undriven, which opens the loop. While the pump is disabled the detector state keeps running. The sample clock has to be several times faster than the comparison rate, and a comparison rate of up to 120 MHz is expected.

Top module: `pfd_antibacklash`

## Requirements
- R1: While rst_n is low, both flags and the hold counter are cleared, and pump_up and pump_dn are 0.
- R2: A low-to-high change on ref_div that is first sampled at clock edge k sets the reference flag at edge k+2. With pol_neg=0 and cp_en=1, that flag appears on pump_up after the same edge, which is three sample edges after the input change when inputs change just after an edge.
- R3: When both flags are set, they stay set for exactly ABL_CYCLES sample cycles (default 2) and then clear in the same cycle. The leading flag therefore stays high for its lead in cycles plus ABL_CYCLES, and the lagging flag stays high for ABL_CYCLES.
- R4: If both inputs rise in the same sample cycle, both flags set together and each stays high for exactly ABL_CYCLES cycles.
- R5: A rising edge on an input whose flag is already set is ignored. This includes the cycle in which the pair clears, so a flag that clears does not immediately set again from that edge.
- R6: Falling edges on ref_div and fb_div have no effect on the flags or the outputs.
- R7: With pol_neg=0, pump_up follows the reference flag and pump_dn follows the feedback flag. With pol_neg=1, pump_up follows the feedback flag and pump_dn follows the reference flag.
- R8: With cp_en=0, pump_up, pump_dn and pump_drive are all 0 and the flags keep operating. With cp_en=1, pump_drive is 1. pol_neg and cp_en act on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference signal (asynchronous) |
| fb_div | input | 1 | Divided feedback signal (asynchronous) |
| pol_neg | input | 1 | 1 = exchange the up and down requests |
| cp_en | input | 1 | 1 = pump driven, 0 = open loop |
| pump_up | output | 1 | Up request to the charge pump |
| pump_dn | output | 1 | Down request to the charge pump |
| pump_drive | output | 1 | 1 when the pump output is driven, 0 when it is three-stated |

## Verification
A flag stuck high shows up as a permanently asserted request within a few cycles of the next edge on the opposite input. A miscounted hold changes the width of the lagging pulse by a whole cycle on the first comparison. A wrong priority between clear and set, in the cycle the pair releases, leaves a flag set again immediately after an expected clear. A stage too many or too few in the synchronizer moves every pulse by one cycle. The reference model compares every output in every cycle, so each of these faults appears within one comparison period of the stimulus that exposes it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // One bit per detector side; rf = reference, fb = feedback.
   typedef struct packed {
      logic fb;
      logic rf;
   } pfd_pair_t;

   localparam int unsigned PFD_MIN_SYNC = 2;
   localparam int unsigned PFD_MIN_HOLD = 1;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise_o
);

   generate
      if (STAGES < pfd_pkg::PFD_MIN_SYNC) begin : g_bad_stages
         $error("pfd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], sig_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);  // R6

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
   import pfd_pkg::*;
#(
   parameter int unsigned ABL_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pfd_pair_t rise_i,
   output pfd_pair_t flag_o
);

   localparam int unsigned CNT_W = (ABL_CYCLES > 1) ? $clog2(ABL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ABL_CYCLES - 1);

   generate
      if (ABL_CYCLES < PFD_MIN_HOLD) begin : g_bad_hold
         $error("pfd_flag_core: ABL_CYCLES must be at least 1");
      end
   endgenerate

   pfd_pair_t flag_q;
   logic      both_set;
   logic      release_now;

   assign both_set = flag_q.rf & flag_q.fb;

   generate
      if (ABL_CYCLES == 1) begin : g_hold_one
         assign release_now = both_set;
      end else begin : g_hold_cnt
         logic [CNT_W-1:0] hold_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold_q <= '0;
            else if (!both_set || release_now)
               hold_q <= '0;
            else
               hold_q <= hold_q + 1'b1;
         end

         assign release_now = both_set && (hold_q == LAST_CNT);

         AST_PAIR_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(both_set) |=> both_set);  // R3
      end
   endgenerate

   // Clear has priority: an edge in the releasing cycle finds its flag set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else if (release_now) begin
         flag_q <= '0;
      end else begin
         if (rise_i.rf) flag_q.rf <= 1'b1;
         if (rise_i.fb) flag_q.fb <= 1'b1;
      end
   end

   assign flag_o = flag_q;

   AST_PAIR_DROP_RF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q.rf) |-> $fell(flag_q.fb));  // R3
   AST_PAIR_DROP_FB: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q.fb) |-> $fell(flag_q.rf));  // R3
   AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i.rf && !both_set) |=> flag_q.rf);  // R2
   AST_HOLD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q.rf && !flag_q.fb) |=> flag_q.rf);  // R5

endmodule

// File: rtl/pfd_pump_map.sv
module pfd_pump_map
   import pfd_pkg::*;
(
   input  logic      pol_neg,
   input  logic      cp_en,
   input  pfd_pair_t flag_i,
   output logic      up_o,
   output logic      dn_o,
   output logic      drive_o
);

   logic up_raw;
   logic dn_raw;

   always_comb begin
      if (pol_neg) begin
         up_raw = flag_i.fb;
         dn_raw = flag_i.rf;
      end else begin
         up_raw = flag_i.rf;
         dn_raw = flag_i.fb;
      end
   end

   assign up_o    = cp_en & up_raw;
   assign dn_o    = cp_en & dn_raw;
   assign drive_o = cp_en;

endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
   import pfd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ABL_CYCLES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_div,
   input  logic fb_div,
   input  logic pol_neg,
   input  logic cp_en,
   output logic pump_up,
   output logic pump_dn,
   output logic pump_drive
);

   localparam int unsigned SIDES = 2;

   logic [SIDES-1:0] raw_in;
   logic [SIDES-1:0] rise_vec;
   pfd_pair_t        rise_pair;
   pfd_pair_t        flag_pair;

   assign raw_in = {fb_div, ref_div};

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[s]),
            .rise_o (rise_vec[s])
         );
      end
   endgenerate

   assign rise_pair.rf = rise_vec[0];
   assign rise_pair.fb = rise_vec[1];

   pfd_flag_core #(.ABL_CYCLES(ABL_CYCLES)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise_pair),
      .flag_o (flag_pair)
   );

   pfd_pump_map u_map (
      .pol_neg (pol_neg),
      .cp_en   (cp_en),
      .flag_i  (flag_pair),
      .up_o    (pump_up),
      .dn_o    (pump_dn),
      .drive_o (pump_drive)
   );

   AST_QUIET_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_en |-> (!pump_up && !pump_dn && !pump_drive));  // R8
   AST_FALL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_pair.rf && !rise_vec[0]) |=> !flag_pair.rf);  // R6

endmodule

// File: tb/pfd_antibacklash_bench.sv
module pfd_antibacklash_bench;

   localparam int ABL = 2;
   localparam int WATCHDOG_CYCLES = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_div = 1'b0;
   logic fb_div = 1'b0;
   logic pol_neg = 1'b0;
   logic cp_en = 1'b1;
   logic pump_up, pump_dn, pump_drive;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pfd_antibacklash #(.SYNC_STAGES(2), .ABL_CYCLES(ABL)) u_pfd_antibacklash (
      .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
      .pol_neg(pol_neg), .cp_en(cp_en),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_drive(pump_drive)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Behavioural reference model: input history, two flags, hold count.
   int hr[3];
   int hf[3];
   int m_ref = 0, m_fb = 0, m_hold = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin hr[i] = 0; hf[i] = 0; end
         m_ref = 0; m_fb = 0; m_hold = 0;
      end else begin
         int ev_r, ev_f;
         ev_r = (hr[1] == 1 && hr[2] == 0) ? 1 : 0;
         ev_f = (hf[1] == 1 && hf[2] == 0) ? 1 : 0;
         if (m_ref == 1 && m_fb == 1) begin
            if (m_hold == ABL - 1) begin
               m_ref = 0; m_fb = 0; m_hold = 0;
            end else begin
               m_hold++;
            end
         end else begin
            m_hold = 0;
            if (ev_r == 1) m_ref = 1;
            if (ev_f == 1) m_fb = 1;
         end
         hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = int'(ref_div);
         hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = int'(fb_div);
      end
   end

   // Every-cycle comparison against the model (R7 mapping, R8 gating).
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int e_up, e_dn, e_dr;
         e_dr = cp_en ? 1 : 0;
         e_up = cp_en ? (pol_neg ? m_fb : m_ref) : 0;
         e_dn = cp_en ? (pol_neg ? m_ref : m_fb) : 0;
         check(int'(pump_up) == e_up, "R7 model pump_up", int'(pump_up), e_up);
         check(int'(pump_dn) == e_dn, "R7 model pump_dn", int'(pump_dn), e_dn);
         check(int'(pump_drive) == e_dr, "R8 model pump_drive", int'(pump_drive), e_dr);
      end
   end

   // One 40-cycle comparison; step -1 means "not used".
   task automatic scenario(input int a, input int b, input int rfall, input int rre,
                           input bit pol, input bit en,
                           input int exp_up, input int exp_dn, input string tag);
      int n_up = 0, n_dn = 0, n_dr = 0;
      pol_neg = pol;
      cp_en   = en;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #2;
         if (i == a)     ref_div = 1'b1;
         if (i == rfall) ref_div = 1'b0;
         if (i == rre)   ref_div = 1'b1;
         if (i == b)     fb_div  = 1'b1;
         if (i == 30) begin ref_div = 1'b0; fb_div = 1'b0; end
         @(negedge clk);
         n_up += int'(pump_up);
         n_dn += int'(pump_dn);
         n_dr += int'(pump_drive);
      end
      check(n_up == exp_up, {tag, " up width"}, n_up, exp_up);
      check(n_dn == exp_dn, {tag, " dn width"}, n_dn, exp_dn);
      check(n_dr == (en ? 40 : 0), {tag, " R8 drive cycles"}, n_dr, en ? 40 : 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pump_up == 1'b0, "R1 reset pump_up", int'(pump_up), 0);
      check(pump_dn == 1'b0, "R1 reset pump_dn", int'(pump_dn), 0);
      @(posedge clk); #2 rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R2 latency: change just after edge k; flag after edge k+3.
      @(posedge clk); #2 ref_div = 1'b1;
      for (int j = 1; j <= 4; j++) begin
         @(negedge clk);
         check(int'(pump_up) == (j == 4 ? 1 : 0), "R2 latency", int'(pump_up), j == 4 ? 1 : 0);
      end
      @(posedge clk); #2 fb_div = 1'b1;
      repeat (8) @(posedge clk);
      #2 ref_div = 1'b0; fb_div = 1'b0;
      repeat (8) @(posedge clk);

      scenario(0, 5, -1, -1, 1'b0, 1'b1, 5 + ABL, ABL, "R3 ref leads");
      scenario(6, 2, -1, -1, 1'b0, 1'b1, ABL, 4 + ABL, "R3 fb leads");
      scenario(0, 0, -1, -1, 1'b0, 1'b1, ABL, ABL, "R4 R6 simultaneous then falls");
      scenario(0, 0, 1, 2, 1'b0, 1'b1, ABL, ABL, "R5 edge in release cycle");
      scenario(0, 10, 2, 4, 1'b0, 1'b1, 10 + ABL, ABL, "R5 re-rise while set");
      scenario(0, 5, -1, -1, 1'b1, 1'b1, ABL, 5 + ABL, "R7 negative polarity");
      scenario(0, 5, -1, -1, 1'b0, 1'b0, 0, 0, "R8 open loop");
      scenario(3, 0, -1, -1, 1'b0, 1'b1, ABL, 3 + ABL, "R8 after reopen");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule